// File: doc/BRIEF.md
# HDLC Frame Check Sequence Unit

This block computes, appends and checks the frame check sequence of HDLC packets one byte per clock. It has two independent byte channels. A packet leaving for the line passes through the transmit channel, and a packet arriving from the line passes through the receive channel. Each channel uses a valid strobe and a last-byte marker. The transmit channel can stall its source with a ready signal while it inserts check bytes.

Four static controls set the behaviour, and they must stay steady for the length of a packet:
- an enable for the check sequence;
- a width select for a 16-bit or a 32-bit code;
- a complement control applied to the value sent on the line;
- a keep control. With it the received check bytes are passed on to software. Without it they are removed.

The transmit side accumulates the code over the payload and sends it after the final payload byte. The receive side runs the same code as bytes arrive and reports a mismatch together with the last byte it delivers.

Top module: `hdlc_crc_unit`

## Requirements
- R1: Each accepted transmit byte appears on txOutData with txOutValid high exactly one clock after acceptance. With the check disabled, the final payload byte carries txOutLast, and txOutLast is never high without txOutValid.
- R2: With the check enabled, the final payload byte is followed by 2 check bytes (16-bit width) or 4 check bytes (32-bit width), sent least significant byte first. txOutLast is raised on the final check byte, and txInReady is low for exactly that many cycles after the last payload byte is accepted.
- R3: The 16-bit code uses generator 0x1021 processed least significant bit first (reflected constant 0x8408) and is preset to all ones. With complement on, the bytes "123456789" yield 0x906E.
- R4: The 32-bit code uses generator 0x04C11DB7 processed least significant bit first (reflected constant 0xEDB88320) and is preset to all ones. With complement on, "123456789" yields 0xCBF43926.
- R5: With complement on, the sent value is the bitwise inverse of the register. With complement off, the raw register is sent.
- R6: The code register returns to the all-ones preset after every packet, so back-to-back packets carry independent codes.
- R7: In receive pass mode (check disabled, or keep set), every received byte appears on rxOutData one clock after it arrives, and rxOutLast marks the final byte.
- R8: In receive strip mode (check enabled, keep clear), the trailing 2 or 4 check bytes never reach the output. Payload bytes leave in order, and the final payload byte carries rxOutLast in the clock after the packet's last input byte.
- R9: rxOutErr is high only together with rxOutLast. It is set exactly when the trailing bytes differ from the code computed over the payload with the same width and complement settings, and it is never set with the check disabled.
- R10: In strip mode, a packet of no more than 2 (16-bit) or 4 (32-bit) bytes produces no output byte.
- R11: During and right after reset, all outputs are low except txInReady, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgCrcEn | input | 1 | Enable check sequence generation and checking |
| cfgCrc32 | input | 1 | 1 selects 32-bit code, 0 selects 16-bit |
| cfgInvert | input | 1 | Complement the code on the line |
| cfgKeepCrc | input | 1 | Pass received check bytes to the output |
| txInValid | input | 1 | Transmit byte present |
| txInData | input | 8 | Transmit payload byte |
| txInLast | input | 1 | Final payload byte of packet |
| txInReady | output | 1 | Transmit byte accepted this cycle when high |
| txOutValid | output | 1 | Outgoing byte valid |
| txOutData | output | 8 | Outgoing byte |
| txOutLast | output | 1 | Final outgoing byte of packet |
| rxInValid | input | 1 | Received byte present |
| rxInData | input | 8 | Received byte |
| rxInLast | input | 1 | Final received byte of packet |
| rxOutValid | output | 1 | Delivered byte valid |
| rxOutData | output | 8 | Delivered byte |
| rxOutLast | output | 1 | Final delivered byte of packet |
| rxOutErr | output | 1 | Check mismatch, valid with rxOutLast |

## Verification
The two functions that share a clock are the end-of-packet comparison and the preset of the code register for the next packet. They coincide when one packet's last byte is followed at once by the next packet's first byte. The bench builds receive streams with no idle cycle between a corrupted packet and a clean one, in both pass and strip modes. It judges the result by the rxOutErr flag on each packet's final delivered byte and by the exact delivered byte sequence, including the bytes popped from the strip delay line across the packet boundary.

// File: rtl/hdlc_crc_pkg.sv
package hdlc_crc_pkg;

  localparam int BYTE_W        = 8;
  localparam int CRC_MAX_W     = 32;
  localparam int MAX_CRC_BYTES = CRC_MAX_W / BYTE_W;
  localparam int SEL_W         = $clog2(MAX_CRC_BYTES);
  localparam int CNT_W         = SEL_W + 1;

  localparam logic [CRC_MAX_W-1:0] POLY16_REFL = 32'h0000_8408;
  localparam logic [CRC_MAX_W-1:0] POLY32_REFL = 32'hEDB8_8320;
  localparam logic [CRC_MAX_W-1:0] GOOD16_INV  = 32'h0000_F0B8;
  localparam logic [CRC_MAX_W-1:0] GOOD32_INV  = 32'hDEBB_20E3;
  localparam logic [CRC_MAX_W-1:0] CRC_PRESET  = '1;

  typedef struct packed {
    logic             txFeed;
    logic             txEmit;
    logic [SEL_W-1:0] txSel;
    logic             txEnd;
    logic             rxFeed;
    logic             rxEnd;
    logic             rxOut;
    logic             rxStrip;
  } crcStrobes_t;

  // One byte through the reflected register, low bit first.
  function automatic logic [CRC_MAX_W-1:0] crcStep(
    input logic [CRC_MAX_W-1:0] cur,
    input logic [BYTE_W-1:0]    din,
    input logic                 wide
  );
    logic [CRC_MAX_W-1:0] c;
    logic [CRC_MAX_W-1:0] poly;
    c    = wide ? cur : {16'h0000, cur[15:0]};
    poly = wide ? POLY32_REFL : POLY16_REFL;
    c[BYTE_W-1:0] = c[BYTE_W-1:0] ^ din;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_crc_ctrl.sv
module hdlc_crc_ctrl
  import hdlc_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgCrcEn,
  input  logic        cfgCrc32,
  input  logic        cfgKeepCrc,
  input  logic        txInValid,
  input  logic        txInLast,
  output logic        txInReady,
  input  logic        rxInValid,
  input  logic        rxInLast,
  output crcStrobes_t stb
);

  typedef enum logic {TX_PAY, TX_EMIT} txState_t;

  txState_t         txState;
  logic [SEL_W-1:0] emitCnt;
  logic [CNT_W-1:0] rxFill;
  logic [CNT_W-1:0] nBytes;
  logic             emitLast;
  logic             stripOn;

  always_comb begin
    nBytes   = cfgCrc32 ? CNT_W'(MAX_CRC_BYTES) : CNT_W'(MAX_CRC_BYTES / 2);
    emitLast = ({1'b0, emitCnt} == (nBytes - CNT_W'(1)));
    stripOn  = cfgCrcEn & ~cfgKeepCrc;

    txInReady   = (txState == TX_PAY);
    stb.txFeed  = txInValid & txInReady;
    stb.txEmit  = (txState == TX_EMIT);
    stb.txSel   = emitCnt;
    stb.txEnd   = (stb.txFeed & txInLast & ~cfgCrcEn) | (stb.txEmit & emitLast);

    stb.rxFeed  = rxInValid;
    stb.rxEnd   = rxInValid & rxInLast;
    stb.rxStrip = stripOn;
    stb.rxOut   = rxInValid & (~stripOn | (rxFill == nBytes));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_PAY;
      emitCnt <= '0;
    end else begin
      case (txState)
        TX_PAY: begin
          if (stb.txFeed && txInLast && cfgCrcEn) begin
            txState <= TX_EMIT;
            emitCnt <= '0;
          end
        end
        TX_EMIT: begin
          if (emitLast) begin
            txState <= TX_PAY;
            emitCnt <= '0;
          end else begin
            emitCnt <= emitCnt + SEL_W'(1);
          end
        end
        default: txState <= TX_PAY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFill <= '0;
    end else if (stb.rxEnd) begin
      rxFill <= '0;
    end else if (stb.rxFeed && (rxFill != nBytes)) begin
      rxFill <= rxFill + CNT_W'(1);
    end
  end

  // R2
  tx_emit_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txFeed && txInLast && cfgCrcEn) |=> !txInReady);

  // R2
  tx_emit_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txEmit && emitLast) |=> txInReady);

  // R8
  rx_fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFill <= CNT_W'(MAX_CRC_BYTES));

endmodule

// File: rtl/hdlc_crc_datapath.sv
module hdlc_crc_datapath
  import hdlc_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCrcEn,
  input  logic              cfgCrc32,
  input  logic              cfgInvert,
  input  crcStrobes_t       stb,
  input  logic [BYTE_W-1:0] txInData,
  input  logic [BYTE_W-1:0] rxInData,
  output logic              txOutValid,
  output logic [BYTE_W-1:0] txOutData,
  output logic              txOutLast,
  output logic              rxOutValid,
  output logic [BYTE_W-1:0] rxOutData,
  output logic              rxOutLast,
  output logic              rxOutErr
);

  localparam logic [SEL_W-1:0] OLD32 = SEL_W'(MAX_CRC_BYTES - 1);
  localparam logic [SEL_W-1:0] OLD16 = SEL_W'(MAX_CRC_BYTES / 2 - 1);

  logic [CRC_MAX_W-1:0] txCrc, rxCrc;
  logic [CRC_MAX_W-1:0] txNext, rxNext, txSendVal, rxCheck, goodVal;
  logic [BYTE_W-1:0]    emitByte, oldest;
  logic [BYTE_W-1:0]    rxDelay [MAX_CRC_BYTES];
  logic                 rxBad;

  always_comb begin
    txNext    = crcStep(txCrc, txInData, cfgCrc32);
    rxNext    = crcStep(rxCrc, rxInData, cfgCrc32);
    txSendVal = cfgInvert ? ~txCrc : txCrc;
    emitByte  = txSendVal[{stb.txSel, 3'b000} +: BYTE_W];
    rxCheck   = cfgCrc32 ? rxNext : {16'h0000, rxNext[15:0]};
    if (cfgCrc32) goodVal = cfgInvert ? GOOD32_INV : '0;
    else          goodVal = cfgInvert ? GOOD16_INV : '0;
    rxBad     = (rxCheck != goodVal);
    oldest    = rxDelay[cfgCrc32 ? OLD32 : OLD16];
  end

  // Transmit path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCrc      <= CRC_PRESET;
      txOutValid <= 1'b0;
      txOutData  <= '0;
      txOutLast  <= 1'b0;
    end else begin
      if (stb.txEnd)       txCrc <= CRC_PRESET;
      else if (stb.txFeed) txCrc <= txNext;
      txOutValid <= stb.txFeed | stb.txEmit;
      txOutLast  <= stb.txEnd;
      if (stb.txEmit)      txOutData <= emitByte;
      else if (stb.txFeed) txOutData <= txInData;
    end
  end

  // Receive path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCrc      <= CRC_PRESET;
      rxOutValid <= 1'b0;
      rxOutData  <= '0;
      rxOutLast  <= 1'b0;
      rxOutErr   <= 1'b0;
    end else begin
      if (stb.rxEnd)       rxCrc <= CRC_PRESET;
      else if (stb.rxFeed) rxCrc <= rxNext;
      rxOutValid <= stb.rxOut;
      rxOutLast  <= stb.rxOut & stb.rxEnd;
      rxOutErr   <= stb.rxOut & stb.rxEnd & cfgCrcEn & rxBad;
      if (stb.rxOut) rxOutData <= stb.rxStrip ? oldest : rxInData;
    end
  end

  generate
    for (genvar g = 0; g < MAX_CRC_BYTES; g++) begin : gDelay
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           rxDelay[g] <= '0;
        else if (stb.rxFeed) rxDelay[g] <= (g == 0) ? rxInData : rxDelay[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  // R1
  tx_last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOutLast |-> txOutValid);

  // R6
  tx_reinit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.txEnd |=> (txCrc == CRC_PRESET));

  // R9
  rx_err_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOutErr |-> (rxOutLast && rxOutValid));

  // R9
  rx_err_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOutErr |-> $past(cfgCrcEn));

endmodule

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit
  import hdlc_crc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgCrcEn,
  input  logic       cfgCrc32,
  input  logic       cfgInvert,
  input  logic       cfgKeepCrc,
  input  logic       txInValid,
  input  logic [7:0] txInData,
  input  logic       txInLast,
  output logic       txInReady,
  output logic       txOutValid,
  output logic [7:0] txOutData,
  output logic       txOutLast,
  input  logic       rxInValid,
  input  logic [7:0] rxInData,
  input  logic       rxInLast,
  output logic       rxOutValid,
  output logic [7:0] rxOutData,
  output logic       rxOutLast,
  output logic       rxOutErr
);

  crcStrobes_t stb;

  hdlc_crc_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgCrcEn   (cfgCrcEn),
    .cfgCrc32   (cfgCrc32),
    .cfgKeepCrc (cfgKeepCrc),
    .txInValid  (txInValid),
    .txInLast   (txInLast),
    .txInReady  (txInReady),
    .rxInValid  (rxInValid),
    .rxInLast   (rxInLast),
    .stb        (stb)
  );

  hdlc_crc_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgCrcEn   (cfgCrcEn),
    .cfgCrc32   (cfgCrc32),
    .cfgInvert  (cfgInvert),
    .stb        (stb),
    .txInData   (txInData),
    .rxInData   (rxInData),
    .txOutValid (txOutValid),
    .txOutData  (txOutData),
    .txOutLast  (txOutLast),
    .rxOutValid (rxOutValid),
    .rxOutData  (rxOutData),
    .rxOutLast  (rxOutLast),
    .rxOutErr   (rxOutErr)
  );

endmodule

// File: tb/test_hdlc_crc_unit.sv
module test_hdlc_crc_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgCrcEn = 1'b0, cfgCrc32 = 1'b0, cfgInvert = 1'b0, cfgKeepCrc = 1'b0;
  logic       txInValid = 1'b0, txInLast = 1'b0;
  logic [7:0] txInData = '0;
  logic       txInReady, txOutValid, txOutLast;
  logic [7:0] txOutData;
  logic       rxInValid = 1'b0, rxInLast = 1'b0;
  logic [7:0] rxInData = '0;
  logic       rxOutValid, rxOutLast, rxOutErr;
  logic [7:0] rxOutData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [9:0] txSeen[$];
  logic [9:0] rxSeen[$];
  logic [9:0] txExp[$];
  logic [9:0] rxExp[$];
  logic [8:0] rxItems[$];

  always #10 clk = ~clk;

  hdlc_crc_unit i_hdlc_crc_unit (.*);

  always @(negedge clk) begin
    if (rstN && txOutValid) txSeen.push_back({1'b0, txOutLast, txOutData});
    if (rstN && rxOutValid) rxSeen.push_back({rxOutErr, rxOutLast, rxOutData});
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    summary();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic cmpQ(input string req, input logic [9:0] got[$], input logic [9:0] expq[$]);
    int bad = -1;
    checks++;
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      if (bad < 0 && got[i] !== expq[i]) bad = i;
    if (bad < 0 && got.size() != expq.size()) bad = (got.size() < expq.size()) ? got.size() : expq.size();
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: at entry %0d actual {err,last,data}=0x%0h (of %0d) expected 0x%0h (of %0d)",
               req, bad, (bad < got.size()) ? got[bad] : 10'h3ff, got.size(),
               (bad < expq.size()) ? expq[bad] : 10'h3ff, expq.size());
    end
  endtask

  // Reference code: feedback bit formed per input bit, register shifted toward bit 0.
  function automatic logic [31:0] refCrc(input logic [7:0] pl[$], input bit wide);
    logic [31:0] st = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] poly = wide ? 32'hEDB8_8320 : 32'h0000_8408;
    for (int i = 0; i < pl.size(); i++)
      for (int k = 0; k < 8; k++) begin
        bit fb = st[0] ^ pl[i][k];
        st = st >> 1;
        if (fb) st = st ^ poly;
      end
    return st;
  endfunction

  function automatic int nCrc();
    return cfgCrc32 ? 4 : 2;
  endfunction

  task automatic setCfg(input bit en, input bit w, input bit inv, input bit keep);
    @(negedge clk);
    cfgCrcEn = en; cfgCrc32 = w; cfgInvert = inv; cfgKeepCrc = keep;
  endtask

  // Send one transmit packet and compare the outgoing stream with the expected one.
  task automatic txPacket(input logic [7:0] pl[$], input string req);
    int lowCnt = 0;
    logic [31:0] c, v;
    txExp.delete();
    for (int i = 0; i < pl.size(); i++)
      txExp.push_back({1'b0, (!cfgCrcEn && i == pl.size() - 1), pl[i]});
    if (cfgCrcEn) begin
      c = refCrc(pl, cfgCrc32);
      v = cfgInvert ? ~c : c;
      for (int b = 0; b < nCrc(); b++) txExp.push_back({1'b0, (b == nCrc() - 1), v[8*b +: 8]});
    end
    for (int i = 0; i < pl.size(); i++) begin
      @(negedge clk);
      while (!txInReady) @(negedge clk);
      txInValid = 1'b1; txInData = pl[i]; txInLast = (i == pl.size() - 1);
    end
    @(negedge clk);
    txInValid = 1'b0; txInLast = 1'b0;
    while (!txInReady && lowCnt < 10) begin lowCnt++; @(negedge clk); end
    // R2: ready held low during check byte insertion
    check(lowCnt == (cfgCrcEn ? nCrc() : 0), {req, " R2 stall length"}, lowCnt, cfgCrcEn ? nCrc() : 0);
    repeat (2) @(negedge clk);
    cmpQ(req, txSeen, txExp);
    txSeen.delete();
  endtask

  // Queue one receive packet into the stream and its expected delivery.
  task automatic rxAdd(input logic [7:0] pl[$], input bit corrupt);
    logic [7:0] fr[$];
    logic [31:0] c, v;
    bit strip = cfgCrcEn && !cfgKeepCrc;
    fr = pl;
    if (cfgCrcEn) begin
      c = refCrc(pl, cfgCrc32);
      v = cfgInvert ? ~c : c;
      for (int b = 0; b < nCrc(); b++) fr.push_back(v[8*b +: 8]);
      if (corrupt) fr[fr.size() - 1] = fr[fr.size() - 1] ^ 8'h01;
    end
    for (int i = 0; i < fr.size(); i++) rxItems.push_back({(i == fr.size() - 1), fr[i]});
    if (strip) begin
      for (int i = 0; i < pl.size(); i++)
        rxExp.push_back({(i == pl.size() - 1) && corrupt, (i == pl.size() - 1), pl[i]});
    end else begin
      for (int i = 0; i < fr.size(); i++)
        rxExp.push_back({(i == fr.size() - 1) && corrupt && cfgCrcEn, (i == fr.size() - 1), fr[i]});
    end
  endtask

  task automatic rxFlush(input string req);
    for (int i = 0; i < rxItems.size(); i++) begin
      @(negedge clk);
      rxInValid = 1'b1; rxInLast = rxItems[i][8]; rxInData = rxItems[i][7:0];
    end
    @(negedge clk);
    rxInValid = 1'b0; rxInLast = 1'b0;
    repeat (3) @(negedge clk);
    cmpQ(req, rxSeen, rxExp);
    rxSeen.delete(); rxExp.delete(); rxItems.delete();
  endtask

  function automatic void randPl(ref logic [7:0] pl[$], input int len);
    pl.delete();
    for (int i = 0; i < len; i++) pl.push_back(8'($urandom));
  endfunction

  initial begin
    logic [7:0] pl[$];
    logic [7:0] digits[$];
    void'($urandom(32'd4242));
    for (int i = 0; i < 9; i++) digits.push_back(8'h31 + 8'(i));

    repeat (3) @(negedge clk);
    // R11: outputs during reset
    check({txOutValid, txOutLast, rxOutValid, rxOutLast, rxOutErr} == 5'b0 && txInReady,
          "R11 in reset", {txOutValid, txOutLast, rxOutValid, rxOutLast, rxOutErr, txInReady}, 6'b000001);
    rstN = 1'b1;
    @(negedge clk);
    check({txOutValid, txOutLast, rxOutValid, rxOutLast, rxOutErr} == 5'b0 && txInReady,
          "R11 after reset", {txOutValid, txOutLast, rxOutValid, rxOutLast, rxOutErr, txInReady}, 6'b000001);

    // R1: one-cycle latency, check disabled
    setCfg(0, 0, 0, 0);
    txInValid = 1'b1; txInData = 8'hA5; txInLast = 1'b1;
    @(negedge clk);
    txInValid = 1'b0; txInLast = 1'b0;
    check(txOutValid && txOutLast && txOutData == 8'hA5, "R1 latency",
          {txOutValid, txOutLast, txOutData}, {2'b11, 8'hA5});
    @(negedge clk);
    txSeen.delete();

    // R3 / R4 / R5: known vectors
    setCfg(1, 1, 1, 0);
    txPacket(digits, "R4 R5 crc32 vector");
    check(refCrc(digits, 1) == ~32'hCBF43926, "R4 reference model", refCrc(digits, 1), ~32'hCBF43926);
    txExp.delete();
    setCfg(1, 1, 1, 0);
    for (int i = 0; i < 9; i++) txExp.push_back({2'b00, digits[i]});
    txExp.push_back(10'h026); txExp.push_back(10'h039); txExp.push_back(10'h0F4); txExp.push_back(10'h1CB);
    begin
      logic [9:0] hold[$];
      hold = txExp;
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        while (!txInReady) @(negedge clk);
        txInValid = 1'b1; txInData = digits[i]; txInLast = (i == 8);
      end
      @(negedge clk); txInValid = 1'b0; txInLast = 1'b0;
      repeat (7) @(negedge clk);
      cmpQ("R4 literal 0xCBF43926", txSeen, hold);
      txSeen.delete();
      hold.delete();
      setCfg(1, 0, 1, 0);
      for (int i = 0; i < 9; i++) hold.push_back({2'b00, digits[i]});
      hold.push_back(10'h06E); hold.push_back(10'h190);
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        while (!txInReady) @(negedge clk);
        txInValid = 1'b1; txInData = digits[i]; txInLast = (i == 8);
      end
      @(negedge clk); txInValid = 1'b0; txInLast = 1'b0;
      repeat (5) @(negedge clk);
      cmpQ("R3 literal 0x906E", txSeen, hold);
      txSeen.delete();
      hold.delete();
      setCfg(1, 1, 0, 0);
      for (int i = 0; i < 9; i++) hold.push_back({2'b00, digits[i]});
      hold.push_back(10'h0D9); hold.push_back(10'h0C6); hold.push_back(10'h00B); hold.push_back(10'h134);
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        while (!txInReady) @(negedge clk);
        txInValid = 1'b1; txInData = digits[i]; txInLast = (i == 8);
      end
      @(negedge clk); txInValid = 1'b0; txInLast = 1'b0;
      repeat (7) @(negedge clk);
      cmpQ("R5 raw register sent", txSeen, hold);
      txSeen.delete();
    end

    // R6: identical packets back to back give identical codes
    setCfg(1, 0, 1, 0);
    randPl(pl, 5);
    txPacket(pl, "R6 first packet");
    txPacket(pl, "R6 repeat packet");

    // Random transmit packets over all settings (R1 R2 R5)
    for (int n = 0; n < 24; n++) begin
      setCfg(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2);
      randPl(pl, 1 + ($urandom % 12));
      txPacket(pl, "R2 random transmit");
    end

    // R7: pass modes
    setCfg(0, 1, 0, 0);
    randPl(pl, 6); rxAdd(pl, 0); rxFlush("R7 check disabled");
    setCfg(1, 1, 1, 1);
    randPl(pl, 4); rxAdd(pl, 1); rxFlush("R7 keep with bad code");

    // R8: strip, both widths
    setCfg(1, 0, 1, 0);
    randPl(pl, 7); rxAdd(pl, 0); rxFlush("R8 strip 16");
    setCfg(1, 1, 0, 0);
    randPl(pl, 1); rxAdd(pl, 0); rxFlush("R8 strip 32 single byte");

    // R10: frames made only of check bytes
    setCfg(1, 1, 1, 0);
    pl.delete(); rxAdd(pl, 0); rxFlush("R10 strip 32 empty payload");
    setCfg(1, 0, 0, 0);
    pl.delete(); rxAdd(pl, 1); rxFlush("R10 strip 16 empty payload");

    // R9 with R6: back-to-back packets, end compare and preset in one cycle
    setCfg(1, 1, 1, 0);
    randPl(pl, 3); rxAdd(pl, 1);
    randPl(pl, 5); rxAdd(pl, 0);
    randPl(pl, 2); rxAdd(pl, 1);
    rxFlush("R9 back to back strip 32");
    setCfg(1, 0, 0, 1);
    randPl(pl, 4); rxAdd(pl, 1);
    randPl(pl, 4); rxAdd(pl, 0);
    rxFlush("R9 back to back keep 16");

    // Random receive packets (R7 R8 R9)
    for (int n = 0; n < 30; n++) begin
      setCfg(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2);
      randPl(pl, 1 + ($urandom % 10)); rxAdd(pl, ($urandom % 3) == 0);
      randPl(pl, 1 + ($urandom % 10)); rxAdd(pl, ($urandom % 3) == 0);
      rxFlush("R9 random receive");
    end

    summary();
  end

endmodule